// File: doc/BRIEF.md
# Tile Row Planar Pixel Fetcher

The block reads one eight-pixel row of a tile from pattern memory and turns the planar bytes into a stream of per-pixel color indices. A requester presents a tile base address, a row number (0 to 7), a layout mode and an optional double-width flag, and pulses `start`. The block then issues reads on a memory port whose data returns one cycle after the read strobe. Once every plane byte is held, it emits one pixel per cycle, with `pix_valid` high, and then raises `pix_done` for one cycle.

There are three layouts. Two of them use one byte per read: two planes per row, or four planes per row. The third packs two planes into each 16-bit word, so four planes arrive in two reads. In the four-plane layouts a sprite can use the upper plane pair as a second block of eight pixels. This gives sixteen 2-bit pixels per row instead of eight 4-bit ones. Palette lookup, priority and bank translation stay with the neighbouring blocks.

Top module: `tile_row_fetcher`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `mem_rd`, `pix_valid` and `pix_done` are all low.
- R2: Mode code 0 (two planes, byte bus) reads the bytes at base+row and base+row+8, in that order. Each pixel is {0,0,p1,p0}, and plane bit 7 is emitted first.
- R3: Mode code 1 (four planes, byte bus) reads base+row, base+row+8, base+row+16 and base+row+24, in that order. The byte read k is plane k, and each pixel is {p3,p2,p1,p0}, with bit 7 first.
- R4: Mode code 2 (four planes, word bus) reads the word at base+2*row and then the word at base+16+2*row. The first word gives plane 0 in bits 7:0 and plane 2 in bits 15:8. The second gives plane 1 in bits 7:0 and plane 3 in bits 15:8. Pixels are {p3,p2,p1,p0}.
- R5: Mode code 3 behaves exactly like mode code 0.
- R6: With `wide` set in mode 1 or 2, sixteen pixels come out. The first eight are {0,0,p1,p0} and the last eight are {0,0,p3,p2}, each group with bit 7 first. In modes 0 and 3, `wide` has no effect.
- R7: The first read comes in the cycle after `start` is accepted, and the reads follow on consecutive cycles. The first pixel comes two cycles after the last read, and the pixels follow on consecutive cycles.
- R8: `pix_done` is high for exactly one cycle, right after the last pixel. `busy` is low in the cycle after that.
- R9: `start` is ignored while `busy` is high, including during the `pix_done` cycle. The row in progress and its reads are unchanged, and no extra fetch follows.
- R10: `mem_rd` is only high during the fetch cycles of an accepted request.
- R11: Memory addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a row fetch |
| tile_base | input | ADDR_W | Byte address of the tile |
| row | input | 3 | Row within the tile |
| mode | input | 2 | Layout code (0, 1, 2; 3 acts as 0) |
| wide | input | 1 | Sixteen-pixel sprite option |
| busy | output | 1 | Request in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| pix_valid | output | 1 | Pixel strobe |
| pix_data | output | 4 | Color index of the current pixel |
| pix_done | output | 1 | Pulse after the last pixel |

## Verification
The bench builds the block with ADDR_W set to 12. This puts the top of the address space within reach, so tiles placed near 0xFFF show their later plane reads wrapping to low addresses, in both the byte-bus and the word-bus layouts. The memory model hands back a full 16-bit word on every read, so a wrong byte lane or a wrong plane order changes the expected pixel values. The bench raises `start` in the middle of a fetch and again during the done cycle, to show that neither one adds a read.

// File: rtl/trf_pkg.sv
package trf_pkg;
   localparam int TRF_PLANES  = 4;
   localparam int TRF_PLANE_W = 8;
   localparam int TRF_ROW_W   = 3;
   localparam int TRF_PIX_W   = 4;
   localparam int TRF_MAX_PIX = 2 * TRF_PLANE_W;
   localparam int TRF_CNT_W   = $clog2(TRF_MAX_PIX);
   localparam int TRF_IDX_W   = $clog2(TRF_PLANES);
   localparam int TRF_WORD_W  = 2 * TRF_PLANE_W;

   typedef enum logic [1:0] {
      TRF_2BPP_B8  = 2'd0,
      TRF_4BPP_B8  = 2'd1,
      TRF_4BPP_B16 = 2'd2,
      TRF_RSVD     = 2'd3
   } trf_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_CAPT, ST_EMIT, ST_DONE
   } trf_state_e;

   function automatic trf_mode_e trf_norm(input logic [1:0] m);
      return (m == 2'd3) ? TRF_2BPP_B8 : trf_mode_e'(m);
   endfunction
endpackage

// File: rtl/trf_ctrl.sv
module trf_ctrl
   import trf_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [ADDR_W-1:0]    tile_base,
   input  logic [TRF_ROW_W-1:0] row,
   input  logic [1:0]           mode,
   input  logic                 wide,
   output logic                 busy,
   output logic                 mem_rd,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 cap_en,
   output logic [TRF_IDX_W-1:0] cap_idx,
   output trf_mode_e            mode_q,
   output logic                 wide_q,
   output logic                 emit,
   output logic [TRF_CNT_W-1:0] pix_idx,
   output logic                 done
);
   trf_state_e             state;
   logic [ADDR_W-1:0]      base_q;
   logic [TRF_ROW_W-1:0]   row_q;
   logic [TRF_IDX_W-1:0]   rd_idx;
   logic [TRF_IDX_W-1:0]   last_rd;
   logic [TRF_CNT_W-1:0]   last_pix;
   logic [ADDR_W-1:0]      offset;

   assign last_rd  = (mode_q == TRF_4BPP_B8) ? TRF_IDX_W'(TRF_PLANES - 1) : TRF_IDX_W'(1);
   assign last_pix = wide_q ? TRF_CNT_W'(TRF_MAX_PIX - 1) : TRF_CNT_W'(TRF_PLANE_W - 1);

   // Byte bus: plane k sits 8*k past the row byte; word bus: two 16-byte halves.
   always_comb begin
      if (mode_q == TRF_4BPP_B16)
         offset = ADDR_W'({rd_idx[0], 4'b0000}) + ADDR_W'({row_q, 1'b0});
      else
         offset = ADDR_W'({rd_idx, 3'b000}) + ADDR_W'(row_q);
   end

   assign mem_addr = base_q + offset;
   assign mem_rd   = (state == ST_FETCH);
   assign busy     = (state != ST_IDLE);
   assign emit     = (state == ST_EMIT);
   assign done     = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_q  <= '0;
         row_q   <= '0;
         mode_q  <= TRF_2BPP_B8;
         wide_q  <= 1'b0;
         rd_idx  <= '0;
         pix_idx <= '0;
         cap_en  <= 1'b0;
         cap_idx <= '0;
      end else begin
         cap_en  <= (state == ST_FETCH);
         cap_idx <= rd_idx;
         case (state)
            ST_IDLE: if (start) begin
               base_q <= tile_base;
               row_q  <= row;
               mode_q <= trf_norm(mode);
               wide_q <= wide && (trf_norm(mode) != TRF_2BPP_B8);
               rd_idx <= '0;
               state  <= ST_FETCH;
            end
            ST_FETCH: begin
               rd_idx <= rd_idx + 1'b1;
               if (rd_idx == last_rd) state <= ST_CAPT;
            end
            ST_CAPT: begin
               pix_idx <= '0;
               state   <= ST_EMIT;
            end
            ST_EMIT: begin
               pix_idx <= pix_idx + 1'b1;
               if (pix_idx == last_pix) state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/trf_planes.sv
module trf_planes
   import trf_pkg::*;
(
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     cap_en,
   input  logic [TRF_IDX_W-1:0]                     cap_idx,
   input  trf_mode_e                                mode_q,
   input  logic [TRF_WORD_W-1:0]                    rdata,
   output logic [TRF_PLANES-1:0][TRF_PLANE_W-1:0]   planes
);
   for (genvar g = 0; g < TRF_PLANES; g++) begin : g_plane
      // On the word bus plane g shares word g%2 and sits in lane g/2.
      localparam logic [TRF_IDX_W-1:0] WORD_SEL = TRF_IDX_W'(g % 2);
      localparam bit                   HI_LANE  = (g / 2) != 0;
      logic                   load;
      logic [TRF_PLANE_W-1:0] din;
      always_comb begin
         if (mode_q == TRF_4BPP_B16) begin
            load = cap_en && (cap_idx == WORD_SEL);
            din  = HI_LANE ? rdata[TRF_WORD_W-1:TRF_PLANE_W] : rdata[TRF_PLANE_W-1:0];
         end else begin
            load = cap_en && (cap_idx == TRF_IDX_W'(g));
            din  = rdata[TRF_PLANE_W-1:0];
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    planes[g] <= '0;
         else if (load) planes[g] <= din;
      end
   end
endmodule

// File: rtl/trf_serial.sv
module trf_serial
   import trf_pkg::*;
(
   input  logic [TRF_PLANES-1:0][TRF_PLANE_W-1:0] planes,
   input  logic [TRF_CNT_W-1:0]                   pix_idx,
   input  trf_mode_e                              mode_q,
   input  logic                                   wide_q,
   output logic [TRF_PIX_W-1:0]                   pix
);
   localparam int BIT_W = $clog2(TRF_PLANE_W);
   logic [BIT_W-1:0] b;
   always_comb begin
      b = BIT_W'(TRF_PLANE_W - 1) - pix_idx[BIT_W-1:0];
      if (wide_q)
         pix = pix_idx[BIT_W] ? {2'b00, planes[3][b], planes[2][b]}
                              : {2'b00, planes[1][b], planes[0][b]};
      else if (mode_q == TRF_2BPP_B8)
         pix = {2'b00, planes[1][b], planes[0][b]};
      else
         pix = {planes[3][b], planes[2][b], planes[1][b], planes[0][b]};
   end
endmodule

// File: rtl/tile_row_fetcher.sv
module tile_row_fetcher
   import trf_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     tile_base,
   input  logic [TRF_ROW_W-1:0]  row,
   input  logic [1:0]            mode,
   input  logic                  wide,
   output logic                  busy,
   output logic                  mem_rd,
   output logic [ADDR_W-1:0]     mem_addr,
   input  logic [TRF_WORD_W-1:0] mem_rdata,
   output logic                  pix_valid,
   output logic [TRF_PIX_W-1:0]  pix_data,
   output logic                  pix_done
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("tile_row_fetcher: ADDR_W must cover a 32-byte tile");
   end
   if (TRF_PLANE_W != 8 || TRF_PLANES != 4) begin : g_bad_planes
      $error("tile_row_fetcher: plane geometry must be 4 x 8 bits");
   end

   logic                                   cap_en;
   logic [TRF_IDX_W-1:0]                   cap_idx;
   trf_mode_e                              mode_q;
   logic                                   wide_q;
   logic [TRF_CNT_W-1:0]                   pix_idx;
   logic [TRF_PLANES-1:0][TRF_PLANE_W-1:0] planes;

   trf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .tile_base(tile_base),
      .row(row), .mode(mode), .wide(wide), .busy(busy), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .cap_en(cap_en), .cap_idx(cap_idx),
      .mode_q(mode_q), .wide_q(wide_q), .emit(pix_valid),
      .pix_idx(pix_idx), .done(pix_done)
   );

   trf_planes u_planes (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
      .mode_q(mode_q), .rdata(mem_rdata), .planes(planes)
   );

   trf_serial u_serial (
      .planes(planes), .pix_idx(pix_idx), .mode_q(mode_q),
      .wide_q(wide_q), .pix(pix_data)
   );
endmodule

// File: rtl/trf_checker.sv
module trf_checker
   import trf_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 mem_rd,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic                 pix_valid,
   input logic                 pix_done,
   input logic [TRF_PIX_W-1:0] pix_data,
   input trf_mode_e            mode_q,
   input logic                 wide_q
);
   AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy); // R10
   AST_RD_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && $past(mem_rd) |->
         (ADDR_W'(mem_addr - $past(mem_addr)) == ADDR_W'(8)) ||
         (ADDR_W'(mem_addr - $past(mem_addr)) == ADDR_W'(16))); // R3
   AST_NO_RD_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> !mem_rd); // R7
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      pix_done |-> !pix_valid && $past(pix_valid)); // R8
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_done |=> !busy && !pix_done); // R8
   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && (mode_q == TRF_2BPP_B8 || wide_q) |-> pix_data[3:2] == 2'b00); // R6
   AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> mode_q != TRF_RSVD); // R5
endmodule

bind tile_row_fetcher trf_checker #(.ADDR_W(ADDR_W)) u_trf_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd),
   .mem_addr(mem_addr), .pix_valid(pix_valid), .pix_done(pix_done),
   .pix_data(pix_data), .mode_q(mode_q), .wide_q(wide_q)
);

// File: tb/tile_row_fetcher_bench.sv
module tile_row_fetcher_bench;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] tile_base = '0;
   logic [2:0]    row = '0;
   logic [1:0]    mode = '0;
   logic          wide = 1'b0;
   logic          busy, mem_rd, pix_valid, pix_done;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_rdata = '0;
   logic [3:0]    pix_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   int            q_rd_cyc[$];
   logic [AW-1:0] q_rd_addr[$];
   string         q_rd_tag[$];
   int            q_px_cyc[$];
   logic [3:0]    q_px[$];
   string         q_px_tag[$];
   int            q_dn_cyc[$];

   tile_row_fetcher #(.ADDR_W(AW)) u_tile_row_fetcher (
      .clk(clk), .rst_n(rst_n), .start(start), .tile_base(tile_base),
      .row(row), .mode(mode), .wide(wide), .busy(busy), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
      .pix_data(pix_data), .pix_done(pix_done)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
      return 8'(a * 29 + (a >> 5) * 3 + 8'h5A);
   endfunction

   // One-cycle read latency memory, always returning the full word.
   always @(posedge clk) if (mem_rd) mem_rdata <= {byte_at(mem_addr + 1'b1), byte_at(mem_addr)};

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // Monitor: pops the scoreboard as the design produces results.
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (mem_rd) begin
            if (q_rd_addr.size() == 0) check(1'b0, "R10", "unexpected read", int'(mem_addr), 0);
            else begin
               int c; logic [AW-1:0] a; string t;
               c = q_rd_cyc.pop_front(); a = q_rd_addr.pop_front(); t = q_rd_tag.pop_front();
               check(mem_addr == a, t, "read address", int'(mem_addr), int'(a));
               check(cyc == c, "R7", "read cycle", cyc, c);
            end
         end
         if (pix_valid) begin
            if (q_px.size() == 0) check(1'b0, "R9", "unexpected pixel", int'(pix_data), 0);
            else begin
               int c; logic [3:0] p; string t;
               c = q_px_cyc.pop_front(); p = q_px.pop_front(); t = q_px_tag.pop_front();
               check(pix_data == p, t, "pixel value", int'(pix_data), int'(p));
               check(cyc == c, "R7", "pixel cycle", cyc, c);
            end
         end
         if (pix_done) begin
            if (q_dn_cyc.size() == 0) check(1'b0, "R8", "unexpected done", 1, 0);
            else begin
               int c;
               c = q_dn_cyc.pop_front();
               check(cyc == c, "R8", "done cycle", cyc, c);
            end
         end
      end
   end

   // Driver: computes expectations from the requirements and issues a request.
   // glitch 1: start held mid-fetch with another base; glitch 2: start in the done cycle.
   task automatic run_row(input logic [AW-1:0] base, input logic [2:0] r, input logic [1:0] m_in,
                          input bit w_in, input int glitch, input string tag);
      logic [1:0] m; bit w; int nr, np, c;
      logic [AW-1:0] a[4];
      logic [7:0] p[4];
      m  = (m_in == 2'd3) ? 2'd0 : m_in;          // R5
      w  = w_in && (m != 2'd0);                   // R6
      nr = (m == 2'd1) ? 4 : 2;
      np = w ? 16 : 8;
      for (int k = 0; k < 4; k++) begin a[k] = '0; p[k] = '0; end
      if (m == 2'd2) begin                        // R4
         a[0] = base + AW'(2 * r);
         a[1] = base + AW'(16 + 2 * r);
         p[0] = byte_at(a[0]); p[2] = byte_at(a[0] + 1'b1);
         p[1] = byte_at(a[1]); p[3] = byte_at(a[1] + 1'b1);
      end else begin                              // R2, R3
         for (int k = 0; k < nr; k++) begin
            a[k] = base + AW'(8 * k + r);
            p[k] = byte_at(a[k]);
         end
      end
      @(negedge clk);
      tile_base = base; row = r; mode = m_in; wide = w_in; start = 1'b1;
      c = cyc;
      for (int k = 0; k < nr; k++) begin
         q_rd_cyc.push_back(c + 1 + k); q_rd_addr.push_back(a[k]); q_rd_tag.push_back(tag);
      end
      for (int k = 0; k < np; k++) begin
         int b; logic [3:0] v;
         b = 7 - (k % 8);
         if (w) v = (k < 8) ? {2'b00, p[1][b], p[0][b]} : {2'b00, p[3][b], p[2][b]};
         else if (m == 2'd0) v = {2'b00, p[1][b], p[0][b]};
         else v = {p[3][b], p[2][b], p[1][b], p[0][b]};
         q_px_cyc.push_back(c + nr + 2 + k); q_px.push_back(v); q_px_tag.push_back(tag);
      end
      q_dn_cyc.push_back(c + nr + 2 + np);
      @(negedge clk);
      start = 1'b0;
      if (glitch == 1) begin                      // R9
         start = 1'b1; tile_base = ~base; mode = 2'd1;
         repeat (3) @(negedge clk);
         start = 1'b0;
      end
      while (!pix_done) @(negedge clk);
      if (glitch == 2) start = 1'b1;              // R9
      @(negedge clk);
      start = 1'b0;
      check(!busy, "R8", "busy after done", int'(busy), 0);
      if (glitch == 2) begin
         @(negedge clk);
         check(!busy && !mem_rd, "R9", "no fetch after done-cycle start", int'(busy), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !mem_rd && !pix_valid && !pix_done, "R1", "outputs in reset",
            int'({busy, mem_rd, pix_valid, pix_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mem_rd && !pix_valid && !pix_done, "R1", "outputs after reset",
            int'({busy, mem_rd, pix_valid, pix_done}), 0);

      run_row(12'h100, 3'd3, 2'd0, 1'b0, 0, "R2");
      run_row(12'h120, 3'd0, 2'd0, 1'b0, 0, "R2");
      run_row(12'h140, 3'd7, 2'd0, 1'b0, 0, "R2");
      run_row(12'h200, 3'd5, 2'd1, 1'b0, 0, "R3");
      run_row(12'h2A0, 3'd1, 2'd1, 1'b0, 0, "R3");
      run_row(12'h300, 3'd6, 2'd2, 1'b0, 0, "R4");
      run_row(12'h320, 3'd0, 2'd2, 1'b0, 0, "R4");
      run_row(12'h040, 3'd2, 2'd3, 1'b0, 0, "R5");
      run_row(12'h060, 3'd4, 2'd3, 1'b1, 0, "R5");
      run_row(12'h400, 3'd2, 2'd1, 1'b1, 0, "R6");
      run_row(12'h440, 3'd7, 2'd2, 1'b1, 0, "R6");
      run_row(12'h480, 3'd1, 2'd0, 1'b1, 0, "R6");
      run_row(12'h500, 3'd3, 2'd2, 1'b0, 1, "R9");
      run_row(12'h540, 3'd6, 2'd1, 1'b1, 2, "R9");
      run_row(12'hFF0, 3'd7, 2'd1, 1'b0, 0, "R11");
      run_row(12'hFFA, 3'd5, 2'd2, 1'b0, 0, "R11");
      repeat (4) @(negedge clk);
      check(q_rd_addr.size() == 0 && q_px.size() == 0 && q_dn_cyc.size() == 0,
            "R10", "scoreboard drained", q_rd_addr.size() + q_px.size(), 0);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog expired: actual hung expected finished");
      summary();
      $finish;
   end
endmodule